// File: doc/BRIEF.md
# Hall-Sensor Commutation Sequencer

This block turns three already-debounced Hall sensor bits into the six switch enables of a three-phase bridge (one high-side and one low-side switch per phase leg). It drives the motor with a six-step 120-degree conduction pattern at low speed and changes over to a smoother 150-degree pattern on its own. In the 150-degree pattern each phase has a 30-degree dead slot, neighbouring phases overlap, and the edges of every conduction window are chopped to soften the transfer of current between legs.

The block leaves 120-degree drive for 150-degree drive only when three conditions hold. The sensor edges must arrive fast enough, measured on the three-pulse tach. The second Hall bit must have risen twice in a row while that speed held. Every sensor step must follow the commanded direction. A separate timing unit supplies an advance strobe that marks the middle of each 60-degree sector, and the 150-degree pattern uses it to split each sector into two 30-degree slots. A programmable dead time separates the turn-off of one switch of a leg from the turn-on of its partner. The block also produces a one-pulse and a three-pulse tach output per electrical revolution.

Top module: `bldc_hall_sequencer`

## Requirements
- R1: While `rst_n` is low, all six enables and both tach outputs are 0. After reset, drive always starts in the 120-degree pattern.
- R2: `hall_in` bit 2 is the first sensor and bit 0 is the third. Codes 101, 100, 110, 010, 011, 001 are sectors 0 to 5 of forward rotation. Bit 0, 1 and 2 of each enable vector belong to phases U, V and W. With `dir_rev`=0, the 120-degree pattern uses slot s = 2*sector. For phase p (U=0, V=1, W=2), rel = (s - 4p) mod 12. The high side is enabled for rel 0..3 and the low side for rel 6..9. The outputs follow `hall_in` two clock edges later, apart from dead-time hold-off.
- R3: With `dir_rev`=1, the two windows swap roles: the high side uses the low window and the low side uses the high window.
- R4: The high-side enable is ANDed with `pwm_gate`. In 120-degree drive the low side stays fully on.
- R5: 150-degree drive is entered only while every three-pulse tach period is at most `PERIOD_LIM` cycles, and only after two rising edges of `hall_in[1]` have been seen in that state with conforming steps. Until then, drive stays in the 120-degree pattern.
- R6: In 150-degree drive, s = 2*sector + (half XOR `dir_rev`). `half` is cleared on every Hall change and set by `adv_stb`. The high window is rel 11,0,1,2,3 and the low window is rel 5..9. The edge slots of the low-side window (rel 5,9 forward; rel 11,3 reverse) are chopped by `pwm_gate`. Roles swap with `dir_rev` as in R3.
- R7: When more than `PERIOD_LIM` cycles pass without a three-pulse tach rising edge, drive returns to the 120-degree pattern. This includes a stalled rotor.
- R8: A Hall step that does not follow the commanded direction (+1 sector forward, -1 reverse) keeps or returns the drive to the 120-degree pattern.
- R9: While `hall_in` is 000 or 111, all six enables are 0.
- R10: `tach1` follows `hall_in[2]` and `tach3` follows the XOR of the three bits. While `sleep`=1, both tach outputs are 1 and all enables are 0.
- R11: After one switch of a leg turns off, its partner stays off for at least `DEAD_CYC` cycles. Re-enabling the same switch, as PWM chopping does, has no such delay.
- R12: The high and low switch of one leg are never enabled in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hall_in | input | 3 | Debounced Hall bits, bit 2 = first sensor |
| dir_rev | input | 1 | 0 forward, 1 reverse |
| pwm_gate | input | 1 | PWM chopping gate |
| adv_stb | input | 1 | Mid-sector advance strobe from the timing unit |
| sleep | input | 1 | Power-saving request |
| hs_en | output | 3 | High-side enables, bit 0 = U |
| ls_en | output | 3 | Low-side enables, bit 0 = U |
| tach1 | output | 1 | One pulse per electrical revolution |
| tach3 | output | 1 | Three pulses per electrical revolution |

## Verification
Some properties are checked on every cycle. The two switches of a leg are never on together, and the gap before a complementary switch turns on is at least the dead time. Illegal Hall codes and sleep force the drive off one edge later. Sleep holds both tach outputs high, and an overlong tach period drops the 150-degree pattern within two edges. Other behaviour needs whole scenarios: the exact pattern per sector and direction, the double-edge qualification before the change to 150 degrees, the effect of the advance strobe, and the refusal of 150-degree drive during counter-rotation. The bench shows these by spinning the rotor at controlled speeds, and it adds random long-held codes that must always give the 120-degree pattern.

// File: rtl/hcs_pkg.sv
package hcs_pkg;
   localparam int PHASES  = 3;
   localparam int SECTORS = 6;
   localparam int SLOTS   = 12;
   localparam int PH_STEP = SLOTS / PHASES;

   typedef logic [2:0] hall_t;

   // sector index for forward order; 7 marks an illegal code
   function automatic logic [2:0] sector_of(input hall_t h);
      case (h)
         3'b101:  return 3'd0;
         3'b100:  return 3'd1;
         3'b110:  return 3'd2;
         3'b010:  return 3'd3;
         3'b011:  return 3'd4;
         3'b001:  return 3'd5;
         default: return 3'd7;
      endcase
   endfunction

   function automatic logic hall_legal(input hall_t h);
      return (h != 3'b000) && (h != 3'b111);
   endfunction
endpackage

// File: rtl/hcs_pattern.sv
module hcs_pattern
   import hcs_pkg::*;
(
   input  logic [3:0] slot,
   input  logic       wide,
   input  logic       rev,
   input  logic       pwm,
   output logic [2:0] hs_req,
   output logic [2:0] ls_req
);
   for (genvar p = 0; p < PHASES; p++) begin : g_ph
      int   rel;
      logic win_a, win_b, core_a, core_b, h, l;
      always_comb begin
         rel = (int'(slot) + SLOTS - PH_STEP * p) % SLOTS;
         if (wide) begin
            win_a  = (rel >= 11) || (rel <= 3);
            win_b  = (rel >= 5) && (rel <= 9);
            core_a = (rel <= 2);
            core_b = (rel >= 6) && (rel <= 8);
         end else begin
            win_a  = (rel <= 3);
            win_b  = (rel >= 6) && (rel <= 9);
            core_a = win_a;
            core_b = win_b;
         end
         if (!rev) begin
            h = win_a & pwm;
            l = win_b & (core_b | pwm);
         end else begin
            h = win_b & pwm;
            l = win_a & (core_a | pwm);
         end
      end
      assign hs_req[p] = h;
      assign ls_req[p] = l;
   end
endmodule

// File: rtl/hcs_dead_leg.sv
module hcs_dead_leg #(
   parameter int DEAD_CYC = 200
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_hi,
   input  logic req_lo,
   output logic hi_o,
   output logic lo_o
);
   localparam int DW = $clog2(DEAD_CYC + 1);
   localparam logic [DW-1:0] DEAD_V = DW'(DEAD_CYC);

   logic [DW-1:0] cnt;
   logic          last_hi;
   logic          hi_g, lo_g;

   always_comb begin
      hi_g = req_hi & (last_hi | (cnt == '0));
      lo_g = req_lo & ~hi_g & (~last_hi | (cnt == '0));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         last_hi <= 1'b0;
         hi_o    <= 1'b0;
         lo_o    <= 1'b0;
      end else begin
         hi_o <= hi_g;
         lo_o <= lo_g;
         if (hi_g | lo_g)     cnt <= DEAD_V;
         else if (cnt != '0) cnt <= cnt - 1'b1;
         if (hi_g)      last_hi <= 1'b1;
         else if (lo_g) last_hi <= 1'b0;
      end
   end

   // gap counters for the checks below
   logic [DW-1:0] lo_gap, hi_gap;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_gap <= DEAD_V;
         hi_gap <= DEAD_V;
      end else begin
         lo_gap <= lo_o ? '0 : ((lo_gap == DEAD_V) ? lo_gap : lo_gap + 1'b1);
         hi_gap <= hi_o ? '0 : ((hi_gap == DEAD_V) ? hi_gap : hi_gap + 1'b1);
      end
   end

   // R12
   leg_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(hi_o && lo_o));
   // R11
   hi_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hi_o) |-> (lo_gap >= DEAD_V));
   // R11
   lo_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lo_o) |-> (hi_gap >= DEAD_V));
endmodule

// File: rtl/hcs_speed_qual.sv
module hcs_speed_qual
   import hcs_pkg::*;
#(
   parameter int PERIOD_LIM = 16_393_443
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  sleep,
   input  logic  rev,
   input  hall_t hall_cur,
   input  hall_t hall_prev,
   output logic  wide
);
   localparam int CW = $clog2(PERIOD_LIM + 2);
   localparam logic [CW-1:0] LIM_V = CW'(PERIOD_LIM);
   localparam logic [CW-1:0] SAT_V = CW'(PERIOD_LIM + 1);

   logic [CW-1:0] per_cnt;
   logic          fast, conform;
   logic [1:0]    rises;
   logic          change, t3_rise, h2_rise, step_ok;
   logic [2:0]    sc, sp, nxt_f, nxt_r;

   always_comb begin
      sc      = sector_of(hall_cur);
      sp      = sector_of(hall_prev);
      nxt_f   = (sp == 3'd5) ? 3'd0 : sp + 3'd1;
      nxt_r   = (sp == 3'd0) ? 3'd5 : sp - 3'd1;
      change  = (hall_cur != hall_prev);
      t3_rise = (^hall_cur) & ~(^hall_prev);
      h2_rise = hall_cur[1] & ~hall_prev[1];
      step_ok = hall_legal(hall_cur) & hall_legal(hall_prev) &
                (rev ? (sc == nxt_r) : (sc == nxt_f));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         per_cnt <= SAT_V;
         fast    <= 1'b0;
         conform <= 1'b0;
         rises   <= 2'd0;
         wide    <= 1'b0;
      end else begin
         if (t3_rise) begin
            per_cnt <= '0;
            fast    <= ~sleep & (per_cnt <= LIM_V);
         end else begin
            if (per_cnt != SAT_V) per_cnt <= per_cnt + 1'b1;
            if ((per_cnt > LIM_V) || sleep) fast <= 1'b0;
         end
         if (change) conform <= step_ok;
         if (!fast || sleep || (change && !step_ok)) rises <= 2'd0;
         else if (h2_rise && rises != 2'd2)          rises <= rises + 2'd1;
         wide <= fast & conform & (rises == 2'd2) & ~sleep;
      end
   end

   // R7
   slow_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (per_cnt > LIM_V) |-> ##2 !wide);
endmodule

// File: rtl/bldc_hall_sequencer.sv
module bldc_hall_sequencer
   import hcs_pkg::*;
#(
   parameter int DEAD_CYC   = 200,
   parameter int PERIOD_LIM = 16_393_443
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] hall_in,
   input  logic       dir_rev,
   input  logic       pwm_gate,
   input  logic       adv_stb,
   input  logic       sleep,
   output logic [2:0] hs_en,
   output logic [2:0] ls_en,
   output logic       tach1,
   output logic       tach3
);
   if (DEAD_CYC < 1) begin : g_bad_dead
      $error("DEAD_CYC must be at least 1");
   end
   if (PERIOD_LIM < 2) begin : g_bad_lim
      $error("PERIOD_LIM must be at least 2");
   end

   hall_t      hall_q, hall_d;
   logic       half_q, wide;
   logic [2:0] sec;
   logic [3:0] slot;
   logic       off_all;
   logic [2:0] hs_req, ls_req;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hall_q <= 3'b000;
         hall_d <= 3'b000;
         half_q <= 1'b0;
         tach1  <= 1'b0;
         tach3  <= 1'b0;
      end else begin
         hall_q <= hall_in;
         hall_d <= hall_q;
         if ((hall_q != hall_d) || sleep) half_q <= 1'b0;
         else if (adv_stb)                half_q <= 1'b1;
         tach1 <= sleep | hall_q[2];
         tach3 <= sleep | (^hall_q);
      end
   end

   always_comb begin
      sec     = sector_of(hall_q);
      slot    = {sec, 1'b0} | {3'b000, wide & (half_q ^ dir_rev)};
      off_all = ~hall_legal(hall_q) | sleep;
   end

   hcs_speed_qual #(.PERIOD_LIM(PERIOD_LIM)) u_qual (
      .clk(clk), .rst_n(rst_n), .sleep(sleep), .rev(dir_rev),
      .hall_cur(hall_q), .hall_prev(hall_d), .wide(wide)
   );

   hcs_pattern u_pat (
      .slot(slot), .wide(wide), .rev(dir_rev), .pwm(pwm_gate),
      .hs_req(hs_req), .ls_req(ls_req)
   );

   for (genvar p = 0; p < PHASES; p++) begin : g_leg
      hcs_dead_leg #(.DEAD_CYC(DEAD_CYC)) u_leg (
         .clk(clk), .rst_n(rst_n),
         .req_hi(hs_req[p] & ~off_all),
         .req_lo(ls_req[p] & ~off_all),
         .hi_o(hs_en[p]), .lo_o(ls_en[p])
      );
   end

   // R9
   illegal_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!hall_legal(hall_q) || sleep) |=> (hs_en == 3'b000 && ls_en == 3'b000));
   // R10
   sleep_tach_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sleep |=> (tach1 && tach3));
endmodule

// File: tb/bldc_hall_sequencer_test.sv
module bldc_hall_sequencer_test;
   localparam int DEAD = 8;
   localparam int LIM  = 300;

   logic       clk = 1'b0;
   logic       rst_n;
   logic [2:0] hall_in;
   logic       dir_rev, pwm_gate, adv_stb, sleep;
   logic [2:0] hs_en, ls_en;
   logic       tach1, tach3;

   int n_chk = 0;
   int n_bad = 0;
   int cur   = 0;
   bit done  = 0;

   bldc_hall_sequencer #(.DEAD_CYC(DEAD), .PERIOD_LIM(LIM)) uut (
      .clk(clk), .rst_n(rst_n), .hall_in(hall_in), .dir_rev(dir_rev),
      .pwm_gate(pwm_gate), .adv_stb(adv_stb), .sleep(sleep),
      .hs_en(hs_en), .ls_en(ls_en), .tach1(tach1), .tach3(tach3)
   );

   always #5 clk = ~clk;

   function automatic int sec_of(logic [2:0] h);
      case (h)
         3'b101: return 0;
         3'b100: return 1;
         3'b110: return 2;
         3'b010: return 3;
         3'b011: return 4;
         3'b001: return 5;
         default: return -1;
      endcase
   endfunction

   function automatic logic [2:0] hall_of(int s);
      case (s)
         0: return 3'b101;
         1: return 3'b100;
         2: return 3'b110;
         3: return 3'b010;
         4: return 3'b011;
         default: return 3'b001;
      endcase
   endfunction

   // {hs,ls} as the requirements define them
   function automatic logic [5:0] exp_drive(logic [2:0] h, logic rev, logic wide,
                                             logic half, logic pwm, logic slp);
      logic [2:0] hs, ls;
      int sec, sl, rel;
      logic a, b, ca, cb;
      hs = '0; ls = '0;
      sec = sec_of(h);
      if (!slp && sec >= 0) begin
         sl = 2 * sec + (wide ? int'(half ^ rev) : 0);
         for (int p = 0; p < 3; p++) begin
            rel = (sl + 12 - 4 * p) % 12;
            if (wide) begin
               a = (rel >= 11) || (rel <= 3); b = (rel >= 5) && (rel <= 9);
               ca = (rel <= 2); cb = (rel >= 6) && (rel <= 8);
            end else begin
               a = (rel <= 3); b = (rel >= 6) && (rel <= 9);
               ca = a; cb = b;
            end
            if (!rev) begin hs[p] = a & pwm; ls[p] = b & (cb | pwm); end
            else      begin hs[p] = b & pwm; ls[p] = a & (ca | pwm); end
         end
      end
      return {hs, ls};
   endfunction

   task automatic wait_n(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check_val(string req, logic [5:0] act, logic [5:0] expv);
      n_chk++;
      if (act !== expv) begin
         n_bad++;
         $display("FAIL %s: actual=%h expected=%h hall=%b t=%0t", req, act, expv, hall_in, $time);
      end
   endtask

   task automatic check_drive(string req, logic [5:0] expv);
      check_val(req, {hs_en, ls_en}, expv);
   endtask

   task automatic spin(int n, int dstep, bit chk, logic wide, string tag);
      for (int i = 0; i < n; i++) begin
         cur = (cur + dstep + 6) % 6;
         @(negedge clk) hall_in = hall_of(cur);
         if (chk) begin
            wait_n(20);
            check_drive(tag, exp_drive(hall_of(cur), dir_rev, wide, 1'b0, pwm_gate, 1'b0));
            @(negedge clk) adv_stb = 1'b1;
            @(negedge clk) adv_stb = 1'b0;
            wait_n(20);
            check_drive(tag, exp_drive(hall_of(cur), dir_rev, wide, 1'b1, pwm_gate, 1'b0));
            wait_n(57);
         end else begin
            wait_n(99);
         end
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL R1 watchdog: actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      logic [2:0] h;
      logic r, pw, sl;
      string tag;
      void'($urandom(32'd4711));
      rst_n = 1'b0; hall_in = 3'b101; dir_rev = 1'b0; pwm_gate = 1'b1;
      adv_stb = 1'b0; sleep = 1'b0;
      wait_n(3);
      // R1 reset state
      check_drive("R1 reset drive", 6'h00);
      check_val("R1 reset tach", {4'b0, tach1, tach3}, 6'h00);
      @(negedge clk) rst_n = 1'b1;
      wait_n(20);
      check_drive("R1 start in 120", exp_drive(3'b101, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0));

      // R2 slow forward walk, tach check R10
      for (int s = 0; s < 6; s++) begin
         @(negedge clk) hall_in = hall_of(s);
         wait_n(400);
         check_drive("R2 sector", exp_drive(hall_of(s), 1'b0, 1'b0, 1'b0, 1'b1, 1'b0));
         check_val("R10 tach", {4'b0, tach1, tach3}, {4'b0, hall_of(s)[2], ^hall_of(s)});
      end

      // R4 pwm gating
      @(negedge clk) pwm_gate = 1'b0;
      wait_n(10);
      check_drive("R4 pwm low", exp_drive(hall_in, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0));
      @(negedge clk) pwm_gate = 1'b1;

      // R11 dead time: V goes low -> high
      @(negedge clk) hall_in = 3'b101;
      wait_n(400);
      @(negedge clk) hall_in = 3'b110;
      wait_n(5);
      check_val("R11 hold-off", {5'b0, hs_en[1]}, 6'h00);
      wait_n(15);
      check_val("R11 released", {5'b0, hs_en[1]}, 6'h01);

      // R9 illegal codes
      @(negedge clk) hall_in = 3'b111;
      wait_n(5);
      check_drive("R9 code 111", 6'h00);
      @(negedge clk) hall_in = 3'b000;
      wait_n(5);
      check_drive("R9 code 000", 6'h00);
      @(negedge clk) hall_in = 3'b101;
      wait_n(400);

      // R10 sleep
      @(negedge clk) sleep = 1'b1;
      wait_n(5);
      check_drive("R10 sleep drive", 6'h00);
      check_val("R10 sleep tach", {4'b0, tach1, tach3}, 6'h03);
      @(negedge clk) sleep = 1'b0;
      wait_n(400);

      // R5 forward spin-up: still 120 before two qualified edges
      cur = 0;
      spin(6, 1, 1'b0, 1'b0, "");
      spin(2, 1, 1'b1, 1'b0, "R5 not yet qualified");
      spin(10, 1, 1'b0, 1'b0, "");
      // R6 forward 150 pattern with advance strobe
      spin(12, 1, 1'b1, 1'b1, "R6 forward");

      // R7 stall drops back
      wait_n(600);
      check_drive("R7 stall", exp_drive(hall_of(cur), 1'b0, 1'b0, 1'b0, 1'b1, 1'b0));

      // R6 reverse 150 pattern (R3 roles)
      @(negedge clk) dir_rev = 1'b1;
      wait_n(50);
      spin(18, -1, 1'b0, 1'b0, "");
      spin(12, -1, 1'b1, 1'b1, "R6 reverse");

      // R8 counter-rotation keeps 120
      wait_n(600);
      spin(18, 1, 1'b0, 1'b0, "");
      spin(6, 1, 1'b1, 1'b0, "R8 mismatch");
      wait_n(600);

      // random long-held codes (R2 R3 R4 R9 R10)
      for (int i = 0; i < 40; i++) begin
         h  = 3'($urandom % 8);
         r  = 1'($urandom % 2);
         pw = 1'($urandom % 2);
         sl = (($urandom % 8) == 0);
         @(negedge clk) begin
            hall_in = h; dir_rev = r; pwm_gate = pw; sleep = sl;
         end
         wait_n(400);
         if (sl) tag = "R10 random";
         else if (h == 3'b000 || h == 3'b111) tag = "R9 random";
         else if (r) tag = "R3 random";
         else if (!pw) tag = "R4 random";
         else tag = "R2 random";
         check_drive(tag, exp_drive(h, r, 1'b0, 1'b0, pw, sl));
         check_val("R10 random tach", {4'b0, tach1, tach3},
                   {4'b0, sl | h[2], sl | (^h)});
      end
      finish_run();
   end
endmodule